// File: doc/BRIEF.md
# Heartbeat Watchdog with Edge Kick

The block watches a heartbeat line driven by processor software and raises an active-low fault when the line has not changed level for a programmable number of clock cycles. A change in either direction counts as a kick. The heartbeat is brought into the clock domain through a two-flop synchroniser, and a kick is the difference between the synchronised value and its value one cycle earlier.

The watchdog only runs while three conditions hold: the system reset level is released, the supply-good flag is high, and the heartbeat-valid flag is high. The valid flag stands in for an undriven heartbeat pin. If any condition is missing, the counter is held at zero and the fault output is driven high. The fault output is meant to be looped into the manual-reset input of a reset generator. Because reset clears the fault and holds the counter, a stuck heartbeat then produces a steady train of reset pulses.

Top module: `heartbeat_watchdog`

## Requirements
- R1: After the system reset is released with every enable high and no kick, `wd_fault_n` is still high after TIMEOUT-1 rising clock edges and is low after the TIMEOUT-th edge.
- R2: A heartbeat change on `hb_in`, rising or falling, that is made before rising edge k clears the timeout counter at edge k+2. A fault then needs TIMEOUT further edges without a kick, counted from k+2.
- R3: A kick clears an active fault. The output returns high at the same edge where the kick clears the counter. If the kick and the expiry fall on the same edge, the kick wins and the output stays high.
- R4: Once `wd_fault_n` is low, it stays low, and no new period starts, until a kick, `sys_rst`, `supply_ok` low or `hb_valid` low clears it.
- R5: While `sys_rst` is high, the counter is held at zero and `wd_fault_n` is high from the first edge that samples `sys_rst` high. Timing restarts from zero at the first edge that samples it low.
- R6: While `supply_ok` is low, the watchdog is disabled: `wd_fault_n` is high from the next edge and the counter is held at zero.
- R7: While `hb_valid` is low, the watchdog is disabled in the same way, and heartbeat edges have no effect.
- R8: With `wd_fault_n` looped through a reset generator, a stuck heartbeat gives a periodic fault. The spacing between successive falling edges of the fault is TIMEOUT plus the number of edges on which `sys_rst` is sampled high, plus one.
- R9: While `rst_n` is low, synchronous to the clock, `wd_fault_n` is high and the counter and synchroniser are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| sys_rst | input | 1 | System reset level, high while the system is held in reset |
| supply_ok | input | 1 | High when the supply is above its reset threshold |
| hb_valid | input | 1 | High when the heartbeat pin is driven; low models an open pin |
| hb_in | input | 1 | Asynchronous heartbeat from software |
| wd_fault_n | output | 1 | Active-low watchdog fault |

## Verification
Two events can fall on the same clock edge: a kick clearing the counter, and the counter reaching TIMEOUT. The bench sweeps the point at which the heartbeat toggles across every edge of the window, including the expiry edge itself and edges after the fault has begun. For each case it predicts, arithmetically, the cycle of every fault transition. It also closes the loop through a small reset-generator model and judges the fault period and the pulse widths against R8.

// File: rtl/hb_wdt_pkg.sv
// Shared definitions for the heartbeat watchdog.
// Assumes: nothing beyond a single clock domain for the block logic.
package hb_wdt_pkg;

    // Level of the active-low fault output
    typedef enum logic {
        WD_FAULT = 1'b0,
        WD_OK    = 1'b1
    } wd_level_e;

    // Counter width that can hold the value limit
    function automatic int cnt_width(input int limit);
        int w;
        w = 1;
        while ((1 << w) <= limit) w++;
        return w;
    endfunction

endpackage

// File: rtl/hb_sync_edge.sv
// Brings the asynchronous heartbeat into the clock domain with a two-flop
// synchroniser and flags any level change of the synchronised value.
// Assumes: hb_in may change at any time; kick is a one-cycle pulse.
module hb_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hb_in,
    output logic kick
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the heartbeat through the synchroniser chain and keep one old copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], hb_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // A kick is any difference between the synchronised level and its last value
    always_comb kick = sync_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/hb_timeout_cnt.sv
// Counts enabled cycles without a kick and saturates at LIMIT.
// Assumes: LIMIT >= 2; clear and a low run both force the count to zero.
module hb_timeout_cnt #(
    parameter int LIMIT = 16,
    parameter int W     = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clear,
    output logic [W-1:0] count,
    output logic         expiring
);
    localparam logic [W-1:0] LAST = W'(LIMIT);
    localparam logic [W-1:0] PRE  = W'(LIMIT - 1);

    // Advance while running, hold zero when disabled or kicked, stop at LIMIT
    always_ff @(posedge clk) begin
        if (!rst_n)              count <= '0;
        else if (!run || clear)  count <= '0;
        else if (count != LAST)  count <= count + 1'b1;
    end

    // The edge that moves the count onto LIMIT is the expiry edge
    always_comb expiring = run && !clear && (count == PRE);

endmodule

// File: rtl/hb_fault_reg.sv
// Holds the active-low fault level: set on expiry, released by a kick or disable.
// Assumes: expiring is never high together with clear or a low run.
module hb_fault_reg
    import hb_wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    input  logic expiring,
    output logic fault_n
);
    // Latch the fault until something releases it
    always_ff @(posedge clk) begin
        if (!rst_n)              fault_n <= WD_OK;
        else if (!run || clear)  fault_n <= WD_OK;
        else if (expiring)       fault_n <= WD_FAULT;
    end

endmodule

// File: rtl/heartbeat_watchdog.sv
// Top level: watchdog fed by an edge-detected heartbeat. The output is
// intended to drive the manual-reset input of a reset generator.
// Assumes: TIMEOUT >= 2 cycles; sys_rst, supply_ok, hb_valid are synchronous.
module heartbeat_watchdog
    import hb_wdt_pkg::*;
#(
    parameter int TIMEOUT     = 160_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_rst,
    input  logic supply_ok,
    input  logic hb_valid,
    input  logic hb_in,
    output logic wd_fault_n
);
    localparam int CNT_W = cnt_width(TIMEOUT);

    logic             kick;
    logic             run;
    logic             expiring;
    logic [CNT_W-1:0] wd_count;

    // Watchdog counts only outside reset with a good supply and a driven pin
    always_comb run = !sys_rst && supply_ok && hb_valid;

    hb_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .hb_in (hb_in),
        .kick  (kick)
    );

    hb_timeout_cnt #(.LIMIT(TIMEOUT), .W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .clear    (kick),
        .count    (wd_count),
        .expiring (expiring)
    );

    hb_fault_reg u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .clear    (kick),
        .expiring (expiring),
        .fault_n  (wd_fault_n)
    );

endmodule

// File: rtl/heartbeat_watchdog_chk.sv
// Property checker for the heartbeat watchdog, attached by bind below.
module heartbeat_watchdog_chk #(
    parameter int TIMEOUT = 16,
    parameter int CNT_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sys_rst,
    input logic             supply_ok,
    input logic             hb_valid,
    input logic             kick,
    input logic [CNT_W-1:0] wd_count,
    input logic             wd_fault_n
);
    p_fall_at_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_fault_n) |-> (wd_count == CNT_W'(TIMEOUT)));

    p_kick_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (wd_fault_n && wd_count == '0));

    p_fault_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_fault_n && !kick && !sys_rst && supply_ok && hb_valid) |=> !wd_fault_n);

    p_sysrst_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> (wd_fault_n && wd_count == '0));

    p_supply_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (wd_fault_n && wd_count == '0));

    p_invalid_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hb_valid |=> (wd_fault_n && wd_count == '0));

    p_block_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (wd_fault_n && wd_count == '0));

    // Counter never passes the limit (R1)
    always @(negedge clk) begin
        if (rst_n) begin
            a_no_overflow_r1: assert (wd_count <= CNT_W'(TIMEOUT));
        end
    end

endmodule

bind heartbeat_watchdog heartbeat_watchdog_chk #(
    .TIMEOUT (TIMEOUT),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_rst    (sys_rst),
    .supply_ok  (supply_ok),
    .hb_valid   (hb_valid),
    .kick       (kick),
    .wd_count   (wd_count),
    .wd_fault_n (wd_fault_n)
);

// File: tb/heartbeat_watchdog_tb.sv
module heartbeat_watchdog_tb;
    localparam int T    = 16;
    localparam int HOLD = 5;

    logic clk = 1'b0;
    logic rst_n, drv_rst, supply_ok, hb_valid, hb_in, loop_on;
    logic gen_rst;
    int   gen_hold;
    logic sys_rst;
    logic wd_fault_n;
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Reset-generator model: asserts on a low fault, holds HOLD more cycles
    always @(posedge clk) begin
        if (!loop_on) begin
            gen_rst  <= 1'b0;
            gen_hold <= 0;
        end else if (!wd_fault_n) begin
            gen_rst  <= 1'b1;
            gen_hold <= HOLD;
        end else if (gen_hold != 0) begin
            gen_hold <= gen_hold - 1;
        end else begin
            gen_rst <= 1'b0;
        end
    end

    assign sys_rst = loop_on ? gen_rst : drv_rst;

    heartbeat_watchdog #(.TIMEOUT(T)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_rst    (sys_rst),
        .supply_ok  (supply_ok),
        .hb_valid   (hb_valid),
        .hb_in      (hb_in),
        .wd_fault_n (wd_fault_n)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
        end
    endtask

    // Hold system reset, then release at a negedge
    task automatic restart();
        drv_rst = 1'b1;
        repeat (4) step();
        drv_rst = 1'b0;
    endtask

    // Kick effective at edge j (j>=3); fault low iff (n>=T && n<j) || n>=j+T
    task automatic kick_case(input int j);
        string tag;
        restart();
        tag = (j == T) ? "R3 kick-at-expiry" : (j > T) ? "R3/R4 kick-after-fault" : "R2 kick";
        for (int n = 1; n <= j + T; n++) begin
            if (n == j - 2) hb_in = ~hb_in;
            step();
            check(tag, wd_fault_n, ((n >= T && n < j) || n >= j + T) ? 0 : 1);
        end
    endtask

    initial begin
        int falls[4];
        int nf;
        int rst_edges;
        int low_w;
        logic prev;
        rst_n = 1'b0; drv_rst = 1'b1; supply_ok = 1'b1; hb_valid = 1'b1;
        hb_in = 1'b0; loop_on = 1'b0;
        repeat (3) step();
        check("R9 reset level", wd_fault_n, 1);
        rst_n = 1'b1;
        repeat (3) step();
        check("R5 held in sys_rst", wd_fault_n, 1);

        // R1: exact timeout
        restart();
        for (int n = 1; n <= T + 3; n++) begin
            step();
            check("R1 timeout", wd_fault_n, (n >= T) ? 0 : 1);
        end
        // R4: stays low with no kick
        repeat (2 * T) step();
        check("R4 latched", wd_fault_n, 0);
        // R5: sys_rst clears at next edge, restart from zero
        drv_rst = 1'b1;
        step();
        check("R5 sys_rst clears", wd_fault_n, 1);
        drv_rst = 1'b0;
        for (int n = 1; n <= T; n++) begin
            step();
            check("R5 restart", wd_fault_n, (n >= T) ? 0 : 1);
        end

        // R2/R3/R4 sweep of kick position, both edge directions alternate
        for (int j = 3; j <= T + 4; j++) kick_case(j);

        // R6: supply loss clears fault and holds counter
        restart();
        repeat (T) step();
        check("R6 pre fault", wd_fault_n, 0);
        supply_ok = 1'b0;
        step();
        check("R6 supply low clears", wd_fault_n, 1);
        repeat (3 * T) step();
        check("R6 held off", wd_fault_n, 1);
        supply_ok = 1'b1;
        for (int n = 1; n <= T; n++) begin
            step();
            check("R6 restart", wd_fault_n, (n >= T) ? 0 : 1);
        end

        // R7: invalid pin disables, edges ignored
        hb_valid = 1'b0;
        step();
        check("R7 invalid clears", wd_fault_n, 1);
        for (int n = 0; n < 3 * T; n++) begin
            if (n % 5 == 0) hb_in = ~hb_in;
            step();
        end
        check("R7 held off", wd_fault_n, 1);
        repeat (4) step();
        hb_valid = 1'b1;
        for (int n = 1; n <= T; n++) begin
            step();
            check("R7 restart", wd_fault_n, (n >= T) ? 0 : 1);
        end

        // R8: loop fault into reset generator with a stuck heartbeat
        drv_rst = 1'b1;
        step();
        loop_on = 1'b1;
        nf = 0; rst_edges = 0; low_w = 0; prev = 1'b1;
        for (int n = 1; n <= 4 * (T + HOLD + 3) && nf < 4; n++) begin
            step();
            if (nf == 1 && sys_rst) rst_edges++;
            if (nf == 1 && !wd_fault_n) low_w++;
            if (prev && !wd_fault_n) begin
                falls[nf] = n;
                nf++;
            end
            prev = wd_fault_n;
        end
        check("R8 fault count", nf, 4);
        check("R8 first fault", falls[0], T);
        for (int k = 1; k < 4; k++)
            check("R8 period", falls[k] - falls[k-1], T + HOLD + 3);
        check("R8 reset width", rst_edges, HOLD + 2);
        check("R8 fault width", low_w, 2);
        loop_on = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog on the run itself
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule